// File: doc/BRIEF.md
# Dual Divider Phase Comparator Core

This block is the digital heart of a frequency synthesizer loop. A reference divider counts pulses of a reference clock enable and picks one of three division ratios from a two-bit select. A programmable divider counts pulses of the prescaled RF clock enable and divides by a 15-bit value. The two divided ticks feed a phase-frequency detector. It issues up and down commands to an external charge pump and reports a lock flag once the loop has settled.

Everything runs on one system clock. The reference and RF inputs arrive as single-cycle enables sampled on that clock. Control inputs can mute the pump commands and keep the detector running. They can also switch the whole loop off, pass through a current-range select, and route the two divided ticks onto two port pins for test. A divider value of zero shuts the loop down in the same way as the drive-off control.

Top module: `pll_phase_core`

## Requirements
- R1: The reference divider emits a one-cycle tick after every N counted `ref_en` pulses. N is chosen by `ref_sel` as follows: `ref_sel[0]=0` gives 640, `ref_sel=2'b01` gives 1024 and `ref_sel=2'b11` gives 512.
- R2: A nonzero `div_n` makes the programmable divider emit a one-cycle tick every `div_n` counted `rf_en` pulses. A zero `div_n` stops those ticks, forces both pump outputs low and clears the lock flag.
- R3: A reference tick sets the up state and a divider tick sets the down state. When both would be set, both clear in that same update, so coincident ticks produce no command at all.
- R4: While `cp_off` is 1, `pump_up` and `pump_dn` stay 0. The detector and the lock detector keep running underneath.
- R5: While `drive_off` is 1, `drive_en` is 0, both pump outputs are 0, the detector is held cleared and the lock flag drops at the next clock. `drive_en` equals the inverse of `drive_off`.
- R6: `cur_hi` always equals `cur_hi_sel`.
- R7: With `test_route=1`, `pin_p1` shows the reference tick and `pin_p2` shows the divider tick. With `test_route=0`, they show `port_p1` and `port_p2`.
- R8: Each reference tick closes one comparison period. A period is bad if an up or down pulse has spanned 2 counted `ref_en` pulses. `lock_flag` rises at the reference tick that closes the 4th consecutive good period, and it clears at the first bad one.
- R9: `pump_up` and `pump_dn` are never 1 in the same cycle.
- R10: After reset, both pump outputs and `lock_flag` are 0, and both pins show the port values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One pulse per reference clock period |
| rf_en | input | 1 | One pulse per prescaled RF period |
| div_n | input | 15 | Programmable division value; 0 disables the loop |
| ref_sel | input | 2 | Reference ratio select |
| cp_off | input | 1 | Mute pump commands |
| drive_off | input | 1 | Disable drive and the whole loop |
| cur_hi_sel | input | 1 | Pump current range request |
| test_route | input | 1 | Route divided ticks to the port pins |
| port_p1 | input | 1 | Normal value for pin 1 |
| port_p2 | input | 1 | Normal value for pin 2 |
| pump_up | output | 1 | Charge pump up command |
| pump_dn | output | 1 | Charge pump down command |
| cur_hi | output | 1 | Current range passed through |
| drive_en | output | 1 | Drive amplifier enable |
| lock_flag | output | 1 | Loop is phase locked |
| pin_p1 | output | 1 | Port pin 1 |
| pin_p2 | output | 1 | Port pin 2 |

## Verification
The reference tick and the divider tick can land in the same cycle, and the detector must then hold both commands low rather than firing a short pulse. The bench provokes this by matching 512 reference pulses against 256 RF pulses that arrive every other cycle, with phases chosen so that both counts end on the same edge. It then judges that no pump command ever appears and that the lock flag still rises after four comparison periods. Each cycle is also compared against a behavioural reference model, and the run counts how often the coincidence occurred.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;

   // Pump command pair produced by the phase-frequency detector.
   typedef struct packed {
      logic up;
      logic dn;
   } pump_cmd_t;

   // Reference ratio choice decoded from the two select bits.
   typedef enum logic [1:0] {
      RSEL_MID = 2'b00,
      RSEL_HI  = 2'b01,
      RSEL_LO  = 2'b11
   } ref_choice_e;

   function automatic ref_choice_e decode_ref_sel(input logic [1:0] sel);
      if (!sel[0])      return RSEL_MID;
      else if (!sel[1]) return RSEL_HI;
      else              return RSEL_LO;
   endfunction

endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
   parameter int R_LO  = 512,
   parameter int R_MID = 640,
   parameter int R_HI  = 1024
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_en,
   input  logic [1:0] sel,
   output logic       tick
);
   import pll_core_pkg::*;

   localparam int CW = $clog2(R_HI);

   logic [CW-1:0] cnt;
   logic [CW:0]   ratio_m1;

   always_comb begin
      unique case (decode_ref_sel(sel))
         RSEL_HI: ratio_m1 = (CW+1)'(R_HI - 1);
         RSEL_LO: ratio_m1 = (CW+1)'(R_LO - 1);
         default: ratio_m1 = (CW+1)'(R_MID - 1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (ref_en) begin
            if ({1'b0, cnt} >= ratio_m1) begin
               cnt  <= '0;
               tick <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pll_prog_div.sv
module pll_prog_div #(
   parameter int NW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rf_en,
   input  logic [NW-1:0] div_n,
   output logic          tick
);
   logic [NW-1:0] cnt;
   logic [NW-1:0] div_m1;
   logic          zero_div;

   assign zero_div = (div_n == '0);
   assign div_m1   = div_n - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || zero_div) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (rf_en) begin
            if (cnt >= div_m1) begin
               cnt  <= '0;
               tick <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd
   import pll_core_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  logic      ref_tick,
   input  logic      div_tick,
   output pump_cmd_t cmd
);
   pump_cmd_t nxt;

   always_comb begin
      nxt.up = cmd.up | ref_tick;
      nxt.dn = cmd.dn | div_tick;
      if (nxt.up && nxt.dn) begin
         nxt = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cmd <= '0;
      else                cmd <= nxt;
   end

endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
   parameter int LOCK_CYCLES = 4,
   parameter int LOCK_WIDTH  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ref_en,
   input  logic ref_tick,
   input  logic active,
   output logic locked
);
   localparam int WW = $clog2(LOCK_WIDTH + 1);

   logic [WW-1:0] wcnt;
   logic          bad;
   logic          viol;
   logic          good;

   assign viol = active & ref_en & (wcnt >= WW'(LOCK_WIDTH - 1));
   assign good = ~(bad | viol);

   // Width of the current pulse, in counted reference pulses.
   always_ff @(posedge clk) begin
      if (!rst_n || !run || !active) wcnt <= '0;
      else if (ref_en && wcnt < WW'(LOCK_WIDTH)) wcnt <= wcnt + 1'b1;
   end

   // Sticky violation within the present comparison period.
   always_ff @(posedge clk) begin
      if (!rst_n || !run || ref_tick) bad <= 1'b0;
      else                            bad <= bad | viol;
   end

   generate
      if (LOCK_CYCLES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n || !run) locked <= 1'b0;
            else if (ref_tick)  locked <= good;
         end
      end else begin : g_count
         localparam int GW = $clog2(LOCK_CYCLES + 1);
         logic [GW-1:0] gcnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               gcnt   <= '0;
               locked <= 1'b0;
            end else if (ref_tick) begin
               if (good) begin
                  if (gcnt != GW'(LOCK_CYCLES)) gcnt <= gcnt + 1'b1;
                  locked <= (gcnt >= GW'(LOCK_CYCLES - 1));
               end else begin
                  gcnt   <= '0;
                  locked <= 1'b0;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pll_phase_core.sv
module pll_phase_core #(
   parameter int DIV_W        = 15,
   parameter int REF_RATIO_LO  = 512,
   parameter int REF_RATIO_MID = 640,
   parameter int REF_RATIO_HI  = 1024,
   parameter int LOCK_CYCLES   = 4,
   parameter int LOCK_WIDTH    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en,
   input  logic             rf_en,
   input  logic [DIV_W-1:0] div_n,
   input  logic [1:0]       ref_sel,
   input  logic             cp_off,
   input  logic             drive_off,
   input  logic             cur_hi_sel,
   input  logic             test_route,
   input  logic             port_p1,
   input  logic             port_p2,
   output logic             pump_up,
   output logic             pump_dn,
   output logic             cur_hi,
   output logic             drive_en,
   output logic             lock_flag,
   output logic             pin_p1,
   output logic             pin_p2
);
   import pll_core_pkg::*;

   localparam int NPIN = 2;

   generate
      if (!(REF_RATIO_LO < REF_RATIO_MID && REF_RATIO_MID < REF_RATIO_HI)) begin : g_bad_ratio
         $error("reference ratios must rise strictly LO < MID < HI");
      end
      if (DIV_W < 2) begin : g_bad_width
         $error("DIV_W must be at least 2");
      end
      if (LOCK_CYCLES < 1 || LOCK_WIDTH < 1) begin : g_bad_lock
         $error("lock window parameters must be positive");
      end
   endgenerate

   logic      ref_tick;
   logic      div_tick;
   logic      div_zero;
   logic      run;
   pump_cmd_t cmd;

   assign div_zero = (div_n == '0);
   assign run      = ~div_zero & ~drive_off;

   pll_ref_div #(
      .R_LO (REF_RATIO_LO),
      .R_MID(REF_RATIO_MID),
      .R_HI (REF_RATIO_HI)
   ) u_ref (
      .clk   (clk),
      .rst_n (rst_n),
      .ref_en(ref_en),
      .sel   (ref_sel),
      .tick  (ref_tick)
   );

   pll_prog_div #(.NW(DIV_W)) u_prog (
      .clk  (clk),
      .rst_n(rst_n),
      .rf_en(rf_en),
      .div_n(div_n),
      .tick (div_tick)
   );

   pll_pfd u_pfd (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .ref_tick(ref_tick),
      .div_tick(div_tick),
      .cmd     (cmd)
   );

   pll_lock_det #(
      .LOCK_CYCLES(LOCK_CYCLES),
      .LOCK_WIDTH (LOCK_WIDTH)
   ) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .ref_en  (ref_en),
      .ref_tick(ref_tick),
      .active  (cmd.up | cmd.dn),
      .locked  (lock_flag)
   );

   assign pump_up  = cmd.up & run & ~cp_off;
   assign pump_dn  = cmd.dn & run & ~cp_off;
   assign cur_hi   = cur_hi_sel;
   assign drive_en = ~drive_off;

   // Test routing: each pin picks its divided tick or its port value.
   logic [NPIN-1:0] tap;
   logic [NPIN-1:0] port_val;
   logic [NPIN-1:0] pin_q;

   assign tap      = {div_tick, ref_tick};
   assign port_val = {port_p2, port_p1};

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      assign pin_q[i] = test_route ? tap[i] : port_val[i];
   end

   assign pin_p1 = pin_q[0];
   assign pin_p2 = pin_q[1];

endmodule

// File: rtl/pll_phase_core_chk.sv
module pll_phase_core_chk (
   input logic clk,
   input logic rst_n,
   input logic cp_off,
   input logic drive_off,
   input logic div_zero,
   input logic ref_tick,
   input logic pump_up,
   input logic pump_dn,
   input logic lock_flag
);

   // R4
   a_r4_muted_pump: assert property (@(posedge clk) disable iff (!rst_n)
      cp_off |-> (!pump_up && !pump_dn));

   // R5
   a_r5_drive_off_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      drive_off |=> !lock_flag);

   a_r5_drive_off_no_pump: assert property (@(posedge clk) disable iff (!rst_n)
      drive_off |-> (!pump_up && !pump_dn));

   // R2
   a_r2_zero_div_no_pump: assert property (@(posedge clk) disable iff (!rst_n)
      div_zero |-> (!pump_up && !pump_dn));

   a_r2_zero_div_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      div_zero |=> !lock_flag);

   // R9
   a_r9_exclusive_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !(pump_up && pump_dn));

   // R8
   a_r8_lock_at_compare: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_flag) |-> $past(ref_tick));

endmodule

bind pll_phase_core pll_phase_core_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cp_off   (cp_off),
   .drive_off(drive_off),
   .div_zero (div_zero),
   .ref_tick (ref_tick),
   .pump_up  (pump_up),
   .pump_dn  (pump_dn),
   .lock_flag(lock_flag)
);

// File: tb/pll_phase_core_bench.sv
`timescale 1ns/1ps
module pll_phase_core_bench;

   localparam int LCYC = 4;
   localparam int LWID = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_en = 1'b1;
   logic        rf_en = 1'b0;
   logic [14:0] div_n = '0;
   logic [1:0]  ref_sel = 2'b11;
   logic        cp_off = 1'b0;
   logic        drive_off = 1'b0;
   logic        cur_hi_sel = 1'b0;
   logic        test_route = 1'b0;
   logic        port_p1 = 1'b0;
   logic        port_p2 = 1'b0;
   logic        pump_up, pump_dn, cur_hi, drive_en, lock_flag, pin_p1, pin_p2;

   always #5 clk = ~clk;

   pll_phase_core u_pll_phase_core (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .rf_en(rf_en),
      .div_n(div_n), .ref_sel(ref_sel), .cp_off(cp_off),
      .drive_off(drive_off), .cur_hi_sel(cur_hi_sel),
      .test_route(test_route), .port_p1(port_p1), .port_p2(port_p2),
      .pump_up(pump_up), .pump_dn(pump_dn), .cur_hi(cur_hi),
      .drive_en(drive_en), .lock_flag(lock_flag),
      .pin_p1(pin_p1), .pin_p2(pin_p2)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // ---------------- stimulus driver for rf_en ----------------
   int        rf_mode = 0;   // 0 off, 1 every other cycle, 2 pseudo-random
   int        kc = 0;
   bit [15:0] lfsr = 16'hACE1;

   always @(posedge clk) begin
      #1;
      if (!rst_n) kc = 0;
      else        kc = kc + 1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rf_mode)
         1:       rf_en = kc[0];
         2:       rf_en = lfsr[0];
         default: rf_en = 1'b0;
      endcase
   end

   // ---------------- behavioural reference model ----------------
   int m_rc, m_dc, m_wc, m_gc;
   bit m_rt, m_dt, m_up, m_dn, m_bad, m_lk;
   int coincide = 0;
   int model_active = 0;

   function automatic int ref_ratio(input logic [1:0] s);
      if (s[0] == 1'b0) return 640;
      if (s[1] == 1'b0) return 1024;
      return 512;
   endfunction

   always @(posedge clk) begin
      int  r, n, nrc, ndc, nwc, ngc;
      bit  run, nrt, ndt, nu, nd, nbad, nlk, act, viol, ok, a, b;
      if (!rst_n) begin
         m_rc = 0; m_dc = 0; m_wc = 0; m_gc = 0;
         m_rt = 0; m_dt = 0; m_up = 0; m_dn = 0; m_bad = 0; m_lk = 0;
      end else begin
         n   = int'(div_n);
         r   = ref_ratio(ref_sel);
         run = (n != 0) && !drive_off;
         nrc = m_rc; nrt = 0;
         if (ref_en) begin
            if (m_rc >= r - 1) begin nrc = 0; nrt = 1; end
            else nrc = m_rc + 1;
         end
         ndc = m_dc; ndt = 0;
         if (n == 0) ndc = 0;
         else if (rf_en) begin
            if (m_dc >= n - 1) begin ndc = 0; ndt = 1; end
            else ndc = m_dc + 1;
         end
         if (m_rt && m_dt) coincide++;
         if (!run) begin nu = 0; nd = 0; end
         else begin
            a = m_up || m_rt; b = m_dn || m_dt;
            if (a && b) begin nu = 0; nd = 0; end
            else begin nu = a; nd = b; end
         end
         act = m_up || m_dn;
         if (act) model_active++;
         nwc = m_wc; nbad = m_bad; ngc = m_gc; nlk = m_lk;
         if (!run) begin nwc = 0; nbad = 0; ngc = 0; nlk = 0; end
         else begin
            viol = act && ref_en && (m_wc >= LWID - 1);
            if (!act) nwc = 0;
            else if (ref_en && m_wc < LWID) nwc = m_wc + 1;
            if (m_rt) begin
               ok   = !(m_bad || viol);
               ngc  = ok ? ((m_gc + 1 > LCYC) ? LCYC : m_gc + 1) : 0;
               nlk  = ok && (m_gc + 1 >= LCYC);
               nbad = 0;
            end else begin
               nbad = m_bad || viol;
            end
         end
         m_rc = nrc; m_rt = nrt; m_dc = ndc; m_dt = ndt;
         m_up = nu; m_dn = nd; m_wc = nwc; m_bad = nbad; m_gc = ngc; m_lk = nlk;
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      bit run, eu, ed, ep1, ep2;
      if (rst_n) begin
         run = (div_n != 0) && !drive_off;
         eu  = m_up && run && !cp_off;
         ed  = m_dn && run && !cp_off;
         ep1 = test_route ? m_rt : port_p1;
         ep2 = test_route ? m_dt : port_p2;
         check(pump_up == eu,          "R3 pump_up", pump_up, eu);
         check(pump_dn == ed,          "R3 pump_dn", pump_dn, ed);
         check(lock_flag == m_lk,      "R8 lock_flag", lock_flag, m_lk);
         check(pin_p1 == ep1,          "R7 pin_p1", pin_p1, ep1);
         check(pin_p2 == ep2,          "R7 pin_p2", pin_p2, ep2);
         check(drive_en == !drive_off, "R5 drive_en", drive_en, !drive_off);
         check(cur_hi == cur_hi_sel,   "R6 cur_hi", cur_hi, cur_hi_sel);
      end
   end

   // ---------------- helpers ----------------
   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic count_pins(input int cycles, output int c1, output int c2);
      c1 = 0; c2 = 0;
      repeat (cycles) begin
         @(negedge clk);
         if (pin_p1) c1++;
         if (pin_p2) c2++;
      end
   endtask

   task automatic count_pump(input int cycles, output int cp);
      cp = 0;
      repeat (cycles) begin
         @(negedge clk);
         if (pump_up || pump_dn) cp++;
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   // ---------------- main sequence ----------------
   initial begin
      int c1, c2, cp, base;

      // R10: reset state
      port_p1 = 1'b1; port_p2 = 1'b0;
      repeat (2) @(negedge clk);
      check(pump_up == 0 && pump_dn == 0, "R10 pumps in reset", pump_up | pump_dn, 0);
      check(lock_flag == 0, "R10 lock in reset", lock_flag, 0);
      check(pin_p1 == 1 && pin_p2 == 0, "R10 pins show ports", {pin_p2, pin_p1}, 1);

      // R1: ratio 640 / 1024 / 512 seen on pin_p1 in test mode
      test_route = 1'b1; div_n = 15'd100; rf_mode = 1;
      ref_sel = 2'b00; do_reset(); count_pins(6400, c1, c2);
      check(c1 == 10, "R1 ratio 640 ticks", c1, 10);
      check(c2 == 32, "R7 divider ticks on pin_p2 with n=100", c2, 32);
      ref_sel = 2'b01; do_reset(); count_pins(6400, c1, c2);
      check(c1 == 6, "R1 ratio 1024 ticks", c1, 6);
      ref_sel = 2'b11; do_reset(); count_pins(6400, c1, c2);
      check(c1 == 12, "R1 ratio 512 ticks", c1, 12);

      // R2: zero divider gives no divider ticks, no pump, no lock
      div_n = 15'd0; do_reset(); count_pins(3000, c1, c2);
      check(c2 == 0, "R2 zero divider ticks", c2, 0);
      check(lock_flag == 0, "R2 zero divider lock", lock_flag, 0);

      // R3/R8: coincident ticks, matched frequencies -> no command, lock
      test_route = 1'b0; cur_hi_sel = 1'b1;
      div_n = 15'd256; ref_sel = 2'b11; rf_mode = 1;
      do_reset();
      base = coincide;
      count_pump(2600, cp);
      check(cp == 0, "R3 coincident ticks give no command", cp, 0);
      check(coincide - base >= 4, "R3 coincidences provoked", coincide - base, 4);
      check(lock_flag == 1, "R8 lock after good periods", lock_flag, 1);
      check(cur_hi == 1, "R6 current range follows", cur_hi, 1);

      // R8: mismatch after lock breaks it
      div_n = 15'd257;
      repeat (3000) @(negedge clk);
      check(lock_flag == 0, "R8 lock lost on mismatch", lock_flag, 0);

      // R4: muted pump while detector runs
      cp_off = 1'b1; div_n = 15'd300;
      do_reset();
      base = model_active;
      count_pump(4000, cp);
      check(cp == 0, "R4 pump muted", cp, 0);
      check(model_active - base > 0, "R4 detector still active", model_active - base, 1);
      cp_off = 1'b0;

      // R9 and mixed traffic with pseudo-random RF pulses
      rf_mode = 2; div_n = 15'd3; cur_hi_sel = 1'b0;
      do_reset();
      repeat (5000) @(negedge clk);

      // R5: drive off stops loop and drops lock
      rf_mode = 1; div_n = 15'd256; ref_sel = 2'b11;
      do_reset();
      repeat (2600) @(negedge clk);
      drive_off = 1'b1;
      @(negedge clk);
      check(lock_flag == 0, "R5 lock dropped", lock_flag, 0);
      check(drive_en == 0, "R5 drive disabled", drive_en, 0);
      count_pump(1200, cp);
      check(cp == 0, "R5 no pump while off", cp, 0);
      drive_off = 1'b0;
      repeat (50) @(negedge clk);

      finish_run();
   end

endmodule